// File: doc/BRIEF.md
# Indirect Per-Port Energy-Efficiency Register Window

This block gives a byte-wide host access to a bank of 16-bit energy-efficiency registers. There is one bank for each switch port. The host does not address these registers directly. It first writes a selector byte, which chooses a function table and a port. It then writes an offset byte. After that it reads or writes one data window byte. The block sends each window access to the addressed byte of the selected port's register and returns the read byte on the same cycle.

Each 16-bit register takes two neighbouring offsets. The even offset carries the upper byte and the odd offset carries the lower byte. Each port holds two registers:

- A capability register. Its upper byte shows six read-only link-partner capability flags that come from the port logic. Its lower byte holds a writable local enable bit.
- A wake-error counter. The counter counts wake-error pulses, saturates at its maximum, and clears when the host reads its lower byte.

The selector and offset hold their values until the host rewrites them, so repeated window accesses reach the same byte.

Top module: `eee_indirect_window`

## Requirements
- R1: The selector register (address 0x6E) and the offset register (address 0x6F) reset to 0x00. A read returns the last value written, and the value is held until the same address is written again.
- R2: The window (address 0xA0) is active only when selector bits [7:5] equal 3'b001 and selector bits [3:0] are in 1..4, where that value names the port. Otherwise the window reads 0x00 and a window write changes no state.
- R3: Offset 0x28 reads {1'b0, lp_cap[p*6+5:p*6], 1'b0} for the selected port p (0-based). The capability flags are read-only, and a write to this offset changes nothing.
- R4: Offset 0x29 reads {6'b0, en, 1'b0}. `en` is the port's local enable: it resets to 1, a window write loads it from wdata bit 1, and it drives `local_eee_en[p]`.
- R5: Each cycle with `wake_err[p]` high adds one to port p's 16-bit counter. The counter stops at 0xFFFF. Offset 0x2A reads counter bits [15:8] and offset 0x2B reads bits [7:0].
- R6: A window read of offset 0x2B clears that port's counter and leaves other ports unchanged. If a wake-error pulse arrives in the same cycle, the counter becomes 1. A read of 0x2A does not change the counter.
- R7: Within an active window, any offset other than 0x28..0x2B reads 0x00, and a write to it changes no state.
- R8: Host addresses other than 0x6E, 0x6F and 0xA0 read 0x00.
- R9: A window write or read reaches only the selected port's storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 8 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Write strobe, acts at the rising edge |
| host_rd | input | 1 | Read strobe, used for read-clear events |
| host_rdata | output | 8 | Read data for host_addr, combinational |
| lp_cap | input | NUM_PORTS*6 | Link-partner capability flags, six per port |
| wake_err | input | NUM_PORTS | Wake-error pulse, one per port |
| local_eee_en | output | NUM_PORTS | Local energy-efficiency enable, one per port |

## Verification
The case hardest to reach from the ports is counter saturation. A full 16-bit counter needs tens of thousands of wake-error cycles before the hold at 0xFFFF can be seen. The bench drives one port's pulse input for more than 65,536 cycles without a break, then reads both bytes. It then checks that the first low-byte read clears the counter. A second hard case is a read-clear that lands in the same cycle as a pulse. A directed read asserts the strobe and the pulse together, and the bench expects a count of 1. Random selector values, some of them invalid, are mixed with window traffic so that ignored writes and isolation between ports are exercised.

// File: rtl/eee_iw_pkg.sv
// Package: shared constants for the indirect energy-efficiency window.
// Assumes each table register is 16 bits, split into an even (upper) and odd (lower) offset.
package eee_iw_pkg;
    localparam logic [2:0] FUNC_EEE    = 3'b001;
    localparam logic [7:0] OFF_CAP_HI  = 8'h28;
    localparam logic [7:0] OFF_CAP_LO  = 8'h29;
    localparam logic [7:0] OFF_ERR_HI  = 8'h2A;
    localparam logic [7:0] OFF_ERR_LO  = 8'h2B;
    localparam int         LP_CAP_W    = 6;
    localparam int         LOCAL_BIT   = 1;
endpackage

// File: rtl/eee_iw_addr_latch.sv
// Module: selector/offset latch and window-valid decode.
// Does: holds the function/port selector and the byte offset written by the host.
//       Flags whether the window currently maps onto a port's energy-efficiency table.
// Assumes: a single-cycle write strobe; port numbers are 1-based on the host side.
module eee_iw_addr_latch #(
    parameter int          NUM_PORTS = 4,
    parameter logic [7:0]  CTRL_ADDR = 8'h6E,
    parameter logic [7:0]  OFFS_ADDR = 8'h6F
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] host_addr,
    input  logic [7:0] host_wdata,
    input  logic       host_wr,
    output logic [7:0] ctrl_q,
    output logic [7:0] offs_q,
    output logic [3:0] port_sel,
    output logic       win_valid
);
    import eee_iw_pkg::*;

    localparam logic [3:0] MAX_PORT = 4'(NUM_PORTS);

    // Capture selector and offset on host writes; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            offs_q <= '0;
        end else if (host_wr) begin
            if (host_addr == CTRL_ADDR) ctrl_q <= host_wdata;
            if (host_addr == OFFS_ADDR) offs_q <= host_wdata;
        end
    end

    // Decode the function code and port range into a window-valid flag.
    always_comb begin
        port_sel  = ctrl_q[3:0];
        win_valid = (ctrl_q[7:5] == FUNC_EEE) && (port_sel != 4'd0) && (port_sel <= MAX_PORT);
    end
endmodule

// File: rtl/eee_iw_port_regs.sv
// Module: per-port energy-efficiency register storage.
// Does: holds the local enable bit and the saturating wake-error counter for one port.
//       Returns the byte addressed by the current offset.
// Assumes: wr_en/rd_en are already qualified by the window decode and port select.
module eee_iw_port_regs #(
    parameter int CNT_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic                          rd_en,
    input  logic [7:0]                    offset,
    input  logic [7:0]                    wdata,
    input  logic [eee_iw_pkg::LP_CAP_W-1:0] lp_cap,
    input  logic                          wake_err,
    output logic [7:0]                    rdata,
    output logic                          local_en,
    output logic [CNT_W-1:0]              err_cnt
);
    import eee_iw_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic        clr_evt;
    logic [15:0] cnt_ext;

    // Local enable: writable at the odd capability offset, resets to enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 local_en <= 1'b1;
        else if (wr_en && offset == OFF_CAP_LO)     local_en <= wdata[LOCAL_BIT];
    end

    // Read-clear event comes from a read of the counter's lower byte.
    always_comb clr_evt = rd_en && (offset == OFF_ERR_LO);

    // Wake-error counter: saturating increment, clear on read, pulse survives a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                               err_cnt <= '0;
        else if (clr_evt)                         err_cnt <= wake_err ? CNT_W'(1) : '0;
        else if (wake_err && err_cnt != CNT_MAX)  err_cnt <= err_cnt + CNT_W'(1);
    end

    // Zero-extend the counter to the 16-bit register view.
    always_comb begin
        cnt_ext              = '0;
        cnt_ext[CNT_W-1:0]   = err_cnt;
    end

    // Byte read mux over the two registers; unmapped offsets read zero.
    always_comb begin
        unique case (offset)
            OFF_CAP_HI: rdata = {1'b0, lp_cap, 1'b0};
            OFF_CAP_LO: rdata = {6'b0, local_en, 1'b0};
            OFF_ERR_HI: rdata = cnt_ext[15:8];
            OFF_ERR_LO: rdata = cnt_ext[7:0];
            default:    rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/eee_indirect_window.sv
// Module: top of the indirect per-port register window.
// Does: decodes host byte accesses to the selector, the offset and the data window.
//       Generates per-port write/read enables and muxes the addressed byte back.
// Assumes: host_rdata is sampled combinationally in the cycle of the access;
//          strobes are one clock wide per access.
module eee_indirect_window #(
    parameter int         NUM_PORTS = 4,
    parameter int         CNT_W     = 16,
    parameter logic [7:0] CTRL_ADDR = 8'h6E,
    parameter logic [7:0] OFFS_ADDR = 8'h6F,
    parameter logic [7:0] WIN_ADDR  = 8'hA0
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [7:0]                             host_addr,
    input  logic [7:0]                             host_wdata,
    input  logic                                   host_wr,
    input  logic                                   host_rd,
    output logic [7:0]                             host_rdata,
    input  logic [NUM_PORTS*eee_iw_pkg::LP_CAP_W-1:0] lp_cap,
    input  logic [NUM_PORTS-1:0]                   wake_err,
    output logic [NUM_PORTS-1:0]                   local_eee_en
);
    import eee_iw_pkg::*;

    logic [7:0]                        ctrl_q;
    logic [7:0]                        offs_q;
    logic [3:0]                        port_sel;
    logic                              win_valid;
    logic                              win_hit;
    logic [NUM_PORTS-1:0]              port_wr;
    logic [NUM_PORTS-1:0]              port_rd;
    logic [NUM_PORTS-1:0][7:0]         port_byte;
    logic [NUM_PORTS-1:0][CNT_W-1:0]   err_cnt;
    logic [7:0]                        win_byte;

    eee_iw_addr_latch #(
        .NUM_PORTS (NUM_PORTS),
        .CTRL_ADDR (CTRL_ADDR),
        .OFFS_ADDR (OFFS_ADDR)
    ) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_wr    (host_wr),
        .ctrl_q     (ctrl_q),
        .offs_q     (offs_q),
        .port_sel   (port_sel),
        .win_valid  (win_valid)
    );

    // Window hit: the host addresses the data byte and the selector is valid.
    always_comb win_hit = (host_addr == WIN_ADDR) && win_valid;

    for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_port
        // Per-port enables: only the selected port sees the window strobe.
        always_comb begin
            port_wr[gp] = host_wr && win_hit && (port_sel == 4'(gp + 1));
            port_rd[gp] = host_rd && win_hit && (port_sel == 4'(gp + 1));
        end

        eee_iw_port_regs #(
            .CNT_W (CNT_W)
        ) u_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (port_wr[gp]),
            .rd_en    (port_rd[gp]),
            .offset   (offs_q),
            .wdata    (host_wdata),
            .lp_cap   (lp_cap[gp*LP_CAP_W +: LP_CAP_W]),
            .wake_err (wake_err[gp]),
            .rdata    (port_byte[gp]),
            .local_en (local_eee_en[gp]),
            .err_cnt  (err_cnt[gp])
        );
    end

    // Select the byte of the addressed port for the window.
    always_comb begin
        win_byte = 8'h00;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (win_valid && port_sel == 4'(i + 1)) win_byte = port_byte[i];
        end
    end

    // Host read mux across the three directly addressed bytes.
    always_comb begin
        if (host_addr == CTRL_ADDR)      host_rdata = ctrl_q;
        else if (host_addr == OFFS_ADDR) host_rdata = offs_q;
        else if (host_addr == WIN_ADDR)  host_rdata = win_byte;
        else                             host_rdata = 8'h00;
    end
endmodule

// File: rtl/eee_indirect_window_chk.sv
// Module: assertion checker bound to the indirect window top.
// Does: checks selector hold, invalid-window reads, reserved bits, enable stability
//       and counter saturation.
// Assumes: connected through the bind below to the top's internal nets.
module eee_indirect_window_chk #(
    parameter int         NUM_PORTS = 4,
    parameter int         CNT_W     = 16,
    parameter logic [7:0] CTRL_ADDR = 8'h6E,
    parameter logic [7:0] WIN_ADDR  = 8'hA0
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic [7:0]                         host_addr,
    input logic                               host_wr,
    input logic [7:0]                         host_rdata,
    input logic [7:0]                         ctrl_q,
    input logic [7:0]                         offs_q,
    input logic                               win_valid,
    input logic [NUM_PORTS-1:0]               port_rd,
    input logic [NUM_PORTS-1:0]               local_eee_en,
    input logic [NUM_PORTS-1:0][CNT_W-1:0]    err_cnt
);
    import eee_iw_pkg::*;

    // R1: the selector only changes on a host write to its address.
    a_r1_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_addr == CTRL_ADDR) |=> $stable(ctrl_q));

    // R2: an inactive window always reads zero.
    a_r2_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == WIN_ADDR && !win_valid) |-> host_rdata == 8'h00);

    // R3: the reserved bits of the capability upper byte read zero.
    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == WIN_ADDR && win_valid && offs_q == OFF_CAP_HI)
            |-> (host_rdata[7] == 1'b0 && host_rdata[0] == 1'b0));

    // R4: local enables change only after a window write.
    a_r4_enable_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_addr == WIN_ADDR) |=> $stable(local_eee_en));

    for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_sat
        // R5: a full counter holds unless it is read-cleared.
        a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            (err_cnt[gp] == '1 && !(port_rd[gp] && offs_q == OFF_ERR_LO))
                |=> err_cnt[gp] == '1);
    end
endmodule

bind eee_indirect_window eee_indirect_window_chk #(
    .NUM_PORTS (NUM_PORTS),
    .CNT_W     (CNT_W),
    .CTRL_ADDR (CTRL_ADDR),
    .WIN_ADDR  (WIN_ADDR)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_addr    (host_addr),
    .host_wr      (host_wr),
    .host_rdata   (host_rdata),
    .ctrl_q       (ctrl_q),
    .offs_q       (offs_q),
    .win_valid    (win_valid),
    .port_rd      (port_rd),
    .local_eee_en (local_eee_en),
    .err_cnt      (err_cnt)
);

// File: tb/eee_indirect_window_tb.sv
// Bench: random and directed host traffic against a behavioural model of the window.
module eee_indirect_window_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      host_addr = '0;
    logic [7:0]      host_wdata = '0;
    logic            host_wr = 1'b0;
    logic            host_rd = 1'b0;
    logic [7:0]      host_rdata;
    logic [NP*6-1:0] lp_cap = '0;
    logic [NP-1:0]   wake_err = '0;
    logic [NP-1:0]   local_eee_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // behavioural model state
    logic [7:0]  m_ctrl, m_offs;
    logic [NP-1:0] m_en;
    logic [15:0] m_cnt [NP];

    always #(CLK_PERIOD/2) clk = ~clk;

    eee_indirect_window u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
        .lp_cap(lp_cap), .wake_err(wake_err), .local_eee_en(local_eee_en)
    );

    function automatic bit m_valid();
        return (m_ctrl[7:5] == 3'b001) && (m_ctrl[3:0] >= 4'd1) && (m_ctrl[3:0] <= 4'd4);
    endfunction

    function automatic logic [7:0] m_win();
        int p;
        if (!m_valid()) return 8'h00;
        p = int'(m_ctrl[3:0]) - 1;
        case (m_offs)
            8'h28:   return {1'b0, lp_cap[p*6 +: 6], 1'b0};
            8'h29:   return {6'b0, m_en[p], 1'b0};
            8'h2A:   return m_cnt[p][15:8];
            8'h2B:   return m_cnt[p][7:0];
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] m_read(logic [7:0] a);
        if (a == 8'h6E) return m_ctrl;
        if (a == 8'h6F) return m_offs;
        if (a == 8'hA0) return m_win();
        return 8'h00;
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    function automatic void m_pulse(logic [NP-1:0] m);
        for (int i = 0; i < NP; i++)
            if (m[i] && m_cnt[i] != 16'hFFFF) m_cnt[i] = m_cnt[i] + 16'd1;
    endfunction

    task automatic host_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(posedge clk); #1;
        host_wr = 1'b0;
        if (a == 8'h6E) m_ctrl = d;
        else if (a == 8'h6F) m_offs = d;
        else if (a == 8'hA0 && m_valid() && m_offs == 8'h29)
            m_en[int'(m_ctrl[3:0]) - 1] = d[1];
    endtask

    // read with optional simultaneous wake-error pulse mask
    task automatic host_read(string req, logic [7:0] a, logic [NP-1:0] pm);
        logic [7:0] exp;
        @(negedge clk);
        host_addr = a; host_rd = 1'b1; wake_err = pm;
        #1;
        exp = m_read(a);
        check(req, host_rdata, exp);
        @(posedge clk); #1;
        host_rd = 1'b0; wake_err = '0;
        if (a == 8'hA0 && m_valid() && m_offs == 8'h2B)
            m_cnt[int'(m_ctrl[3:0]) - 1] = 16'h0;
        m_pulse(pm);
    endtask

    task automatic pulses(logic [NP-1:0] pm, int n);
        @(negedge clk);
        wake_err = pm;
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            m_pulse(pm);
        end
        #1 wake_err = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_ctrl = '0; m_offs = '0; m_en = '1;
        for (int i = 0; i < NP; i++) m_cnt[i] = '0;
        lp_cap = 24'hA5_3C_96;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // reset state
        host_read("R1 ctrl reset", 8'h6E, '0);
        host_read("R1 offs reset", 8'h6F, '0);
        check("R4 enable reset", local_eee_en, {NP{1'b1}});
        host_read("R2 window idle", 8'hA0, '0);
        host_read("R8 unmapped addr", 8'h55, '0);

        // R3 capability read and ignored write, port 2
        host_write(8'h6E, 8'h22);
        host_write(8'h6F, 8'h28);
        host_read("R3 cap hi", 8'hA0, '0);
        host_write(8'hA0, 8'hFF);
        host_read("R3 write ignored", 8'hA0, '0);
        host_read("R1 ctrl readback", 8'h6E, '0);

        // R4 local enable on port 3 only, R9 isolation
        host_write(8'h6E, 8'h23);
        host_write(8'h6F, 8'h29);
        host_write(8'hA0, 8'h00);
        host_read("R4 enable cleared", 8'hA0, '0);
        check("R9 other enables intact", local_eee_en, 4'b1011);
        host_write(8'hA0, 8'h02);
        check("R4 enable set", local_eee_en, 4'b1111);

        // R2 invalid selectors: port 0, port 5, wrong function
        host_write(8'h6E, 8'h20);
        host_write(8'hA0, 8'h00);
        host_read("R2 port 0", 8'hA0, '0);
        host_write(8'h6E, 8'h25);
        host_write(8'hA0, 8'h00);
        host_read("R2 port 5", 8'hA0, '0);
        host_write(8'h6E, 8'h41);
        host_write(8'hA0, 8'h00);
        host_read("R2 func", 8'hA0, '0);
        check("R2 no write effect", local_eee_en, 4'b1111);

        // R7 unmapped offset
        host_write(8'h6E, 8'h21);
        host_write(8'h6F, 8'h30);
        host_write(8'hA0, 8'hFF);
        host_read("R7 unmapped offset", 8'hA0, '0);

        // R5 counting and R6 clear with same-cycle pulse, port 1
        pulses(4'b0001, 300);
        host_write(8'h6F, 8'h2A);
        host_read("R5 cnt hi", 8'hA0, '0);
        host_read("R6 hi read keeps", 8'hA0, '0);
        host_write(8'h6F, 8'h2B);
        host_read("R5 cnt lo + R6 clear with pulse", 8'hA0, 4'b0001);
        host_read("R6 counter is one", 8'hA0, '0);
        host_read("R6 counter cleared", 8'hA0, '0);

        // R5 saturation on port 4, R9 counter isolation
        pulses(4'b1000, 65540);
        host_write(8'h6E, 8'h24);
        host_write(8'h6F, 8'h2A);
        host_read("R5 sat hi", 8'hA0, '0);
        host_write(8'h6F, 8'h2B);
        host_read("R5 sat lo", 8'hA0, '0);
        host_read("R6 sat cleared", 8'hA0, '0);

        // constrained random mix
        for (int it = 0; it < 600; it++) begin
            int op;
            op = $urandom_range(0, 9);
            case (op)
                0: host_write(8'h6E, ($urandom_range(0, 7) == 0) ? 8'($urandom)
                                      : {3'b001, 1'($urandom), 4'($urandom_range(0, 5))});
                1: host_write(8'h6F, ($urandom_range(0, 5) == 0) ? 8'($urandom)
                                      : 8'(8'h28 + $urandom_range(0, 3)));
                2: host_write(8'hA0, 8'($urandom));
                3, 4, 5: host_read("R9 random window", 8'hA0, 4'($urandom));
                6: host_read("R1 random regs", 8'($urandom_range(0, 1) ? 8'h6E : 8'h6F), '0);
                7: pulses(4'($urandom), $urandom_range(1, 20));
                8: begin @(negedge clk); lp_cap = 24'($urandom); end
                default: host_read("R8 random addr", 8'($urandom_range(0, 8'h6D)), '0);
            endcase
            if (it % 50 == 0) check("R4 random enables", local_eee_en, m_en);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule